// File: doc/BRIEF.md
# Write-Masked Configuration Register Bank

This block holds a small set of 16-bit control registers for downstream logic such as PHY power and receive-detect enables. Software reaches them through a plain 32-bit write/read port. Every write word carries its own write-enable mask: the upper 16 bits choose which of the lower 16 bits are stored. A single field can therefore change without first reading the register back. Each register's contents drive a slice of a flat control output bus.

A second write path serves hardware sequencers. A request names a field by a small identifier and gives one boolean. The block looks up the field's register, its bit span and its two preset codes, and builds the same kind of masked write internally. The bus port and the field path can act in the same cycle.

Top module: `cfgbank_top`

## Requirements
- R1: On a bus write to a mapped register, data bit i of that register takes `bus_wdata[i]` only when `bus_wdata[i+16]` is 1. Every other bit keeps its value. A write whose mask half is zero changes nothing.
- R2: A mapped register k sits at byte address 4*k, with address bits 1..0 equal to 0. Reading it returns the register in `bus_rdata[15:0]` and zero in `bus_rdata[31:16]`. The read is combinational from `bus_addr`.
- R3: An unmapped address is one whose low two bits are nonzero, or whose address is 4*NUM_REGS or higher. A write there changes no register, and a read there returns zero.
- R4: While `rst_n` is low at a rising clock edge, every register clears to zero on that edge. The reset is synchronous.
- R5: A field request stores the field's preset code in the field's bit span and leaves every other bit of that register unchanged. `fld_on`=1 selects the enable code and `fld_on`=0 selects the disable code. The field table is as follows. Id 0 is register 1 bit 13, with codes 1 and 0. Id 1 is register 1 bit 14, with codes 1 and 0. Id 2 is register 2 bits 1..0, with codes 3 and 2. Id 3 is register 4 bits 3..2, with codes 3 and 2. Id 4 is register 7 bits 15..0, with codes 0x1100 and 0x0188.
- R6: The two one-bit fields of register 1 (ids 0 and 1) update independently, and neither disturbs the other.
- R7: A field request with an id outside the table (5 to 7) changes no register.
- R8: When a bus write and a field request hit the same register in one cycle, the field's bits take the field code and the remaining bits follow the bus write's mask. When they hit different registers, both updates take effect.
- R9: `ctrl_out[16*k+15 : 16*k]` always equals register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (8) | Byte address for read and write |
| bus_wdata | input | 32 | Write mask [31:16] and write data [15:0] |
| bus_rdata | output | 32 | Read data, upper half zero |
| fld_req | input | 1 | Field write request |
| fld_id | input | FID_W (3) | Field identifier |
| fld_on | input | 1 | 1 selects the enable code, 0 selects the disable code |
| ctrl_out | output | 16*NUM_REGS | Flat register contents for downstream logic |

## Verification
The checker covers four behaviours on every cycle. It checks that a plain bus write alters no bit outside its mask, and no bit anywhere when the address is unmapped. It checks that read data matches the addressed register slice and is zero off the map. It checks that out-of-table field requests leave the bank stable, and that reset clears it. The field table's codes and spans need the bench's scenarios, because only a model of the table can tell whether they are right. The same holds for the merge rule when both paths strike one register, and for the exact values that sweeps over every address, register and field id must produce.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int REG_W = 16;
  localparam int BUS_W = 32;

  typedef struct packed {
    logic        valid;
    logic [7:0]  reg_idx;
    logic [3:0]  lo;
    logic [3:0]  hi;
    logic [15:0] on_code;
    logic [15:0] off_code;
  } fld_desc_t;

  // Field table: register index, bit span and the two preset codes.
  function automatic fld_desc_t fld_lookup(input int id);
    fld_desc_t d;
    d = '0;
    case (id)
      0: d = '{1'b1, 8'd1, 4'd13, 4'd13, 16'h0001, 16'h0000};
      1: d = '{1'b1, 8'd1, 4'd14, 4'd14, 16'h0001, 16'h0000};
      2: d = '{1'b1, 8'd2, 4'd0,  4'd1,  16'h0003, 16'h0002};
      3: d = '{1'b1, 8'd4, 4'd2,  4'd3,  16'h0003, 16'h0002};
      4: d = '{1'b1, 8'd7, 4'd0,  4'd15, 16'h1100, 16'h0188};
      default: d = '0;
    endcase
    return d;
  endfunction

  // Build a masked write word: mask for bits lo..hi placed 16 above.
  function automatic logic [BUS_W-1:0] fld_word(input fld_desc_t d, input logic on);
    logic [REG_W-1:0] m;
    logic [REG_W-1:0] code;
    for (int i = 0; i < REG_W; i++)
      m[i] = (i >= int'(d.lo)) && (i <= int'(d.hi));
    code = on ? d.on_code : d.off_code;
    return {m, (code << d.lo) & m};
  endfunction

  // Apply a masked write word to an old register value.
  function automatic logic [REG_W-1:0] masked_merge(input logic [REG_W-1:0] old_v,
                                                    input logic [BUS_W-1:0] word);
    return (old_v & ~word[BUS_W-1:REG_W]) | (word[REG_W-1:0] & word[BUS_W-1:REG_W]);
  endfunction
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] word_idx;

  assign word_idx = addr[ADDR_W-1:2];
  assign hit = (addr[1:0] == 2'b00) && (32'(word_idx) < 32'(NUM_REGS));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel[k] = hit && (32'(word_idx) == 32'(k));
  end
endmodule

// File: rtl/cfgbank_field_enc.sv
module cfgbank_field_enc
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int FID_W    = 3
) (
  input  logic                req,
  input  logic [FID_W-1:0]    id,
  input  logic                on,
  output logic [NUM_REGS-1:0] sel,
  output logic [BUS_W-1:0]    word,
  output logic                valid
);
  fld_desc_t desc;

  assign desc  = fld_lookup(int'(id));
  assign valid = req && desc.valid && (32'(desc.reg_idx) < 32'(NUM_REGS));
  assign word  = fld_word(desc, on);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel[k] = valid && (32'(desc.reg_idx) == 32'(k));
  end
endmodule

// File: rtl/cfgbank_reg.sv
module cfgbank_reg
  import cfgbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_word,
  input  logic             fld_we,
  input  logic [BUS_W-1:0] fld_word_i,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] after_bus;
  logic [REG_W-1:0] after_fld;

  // Bus write first, field write on top: field bits win on overlap.
  always_comb begin
    after_bus = bus_we ? masked_merge(q, bus_word) : q;
    after_fld = fld_we ? masked_merge(after_bus, fld_word_i) : after_bus;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= after_fld;
  end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8,
  parameter int FID_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      fld_req,
  input  logic [FID_W-1:0]          fld_id,
  input  logic                      fld_on,
  output logic [NUM_REGS*16-1:0]    ctrl_out
);
  logic [NUM_REGS-1:0] addr_sel;
  logic                addr_hit;
  logic [NUM_REGS-1:0] fld_sel;
  logic [BUS_W-1:0]    fld_word_w;
  logic                fld_valid;
  logic [REG_W-1:0]    reg_q [NUM_REGS];

  cfgbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) dec_i (
    .addr(bus_addr), .sel(addr_sel), .hit(addr_hit)
  );

  cfgbank_field_enc #(.NUM_REGS(NUM_REGS), .FID_W(FID_W)) fenc_i (
    .req(fld_req), .id(fld_id), .on(fld_on),
    .sel(fld_sel), .word(fld_word_w), .valid(fld_valid)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    cfgbank_reg reg_i (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_wr && addr_sel[k]), .bus_word(bus_wdata),
      .fld_we(fld_sel[k]), .fld_word_i(fld_word_w),
      .q(reg_q[k])
    );
    assign ctrl_out[k*REG_W +: REG_W] = reg_q[k];
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (addr_sel[k]) bus_rdata[REG_W-1:0] = reg_q[k];
  end
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic                   fld_req,
  input logic [NUM_REGS*16-1:0] ctrl_out,
  input logic                   addr_hit,
  input logic                   fld_valid
);
  logic [NUM_REGS*16-1:0] keep;
  logic [15:0]            rd_exp;

  always_comb begin
    keep   = '1;
    rd_exp = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (addr_hit && (32'(bus_addr[ADDR_W-1:2]) == 32'(k))) begin
        keep[k*16 +: 16] = ~bus_wdata[31:16];
        rd_exp           = ctrl_out[k*16 +: 16];
      end
  end

  // R1 R3
  bus_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !fld_req) |=> (((ctrl_out ^ $past(ctrl_out)) & $past(keep)) == '0));

  // R3
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == 32'h0));

  // R2
  mapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (bus_rdata == {16'h0, rd_exp}));

  // R7
  bad_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_req && !fld_valid && !bus_wr) |=> $stable(ctrl_out));

  // R4
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ctrl_out == '0));
endmodule

bind cfgbank_top cfgbank_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fld_req(fld_req),
  .ctrl_out(ctrl_out), .addr_hit(addr_hit), .fld_valid(fld_valid)
);

// File: tb/cfgbank_top_tb_top.sv
module cfgbank_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         fld_req = 1'b0;
  logic [2:0]   fld_id = '0;
  logic         fld_on = 1'b0;
  logic [127:0] ctrl_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mdl [8];

  always #2.5 clk = ~clk;

  cfgbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fld_req(fld_req),
    .fld_id(fld_id), .fld_on(fld_on), .ctrl_out(ctrl_out)
  );

  function automatic logic [127:0] mdl_flat();
    logic [127:0] f;
    for (int k = 0; k < 8; k++) f[k*16 +: 16] = mdl[k];
    return f;
  endfunction

  // Bench view of the field table: register, mask, placed value.
  task automatic fld_model(input int id, input bit on, output int r,
                           output logic [15:0] m, output logic [15:0] v);
    r = 0; m = 16'h0; v = 16'h0;
    case (id)
      0: begin r = 1; m = 16'h2000; v = on ? 16'h2000 : 16'h0000; end
      1: begin r = 1; m = 16'h4000; v = on ? 16'h4000 : 16'h0000; end
      2: begin r = 2; m = 16'h0003; v = on ? 16'h0003 : 16'h0002; end
      3: begin r = 4; m = 16'h000C; v = on ? 16'h000C : 16'h0008; end
      4: begin r = 7; m = 16'hFFFF; v = on ? 16'h1100 : 16'h0188; end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] m, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {m, d};
    @(negedge clk);
    bus_wr = 1'b0;
    if (a[1:0] == 2'b00 && a < 8'h20)
      mdl[a >> 2] = (mdl[a >> 2] & ~m) | (d & m);
  endtask

  task automatic field_write(input int id, input bit on);
    int r; logic [15:0] m; logic [15:0] v;
    @(negedge clk);
    fld_req = 1'b1; fld_id = 3'(id); fld_on = on;
    @(negedge clk);
    fld_req = 1'b0;
    fld_model(id, on, r, m, v);
    mdl[r] = (mdl[r] & ~m) | v;
  endtask

  task automatic read_check(input string tag, input logic [7:0] a);
    logic [31:0] exp;
    bus_addr = a;
    #1;
    exp = (a[1:0] == 2'b00 && a < 8'h20) ? {16'h0, mdl[a >> 2]} : 32'h0;
    check(tag, {96'h0, bus_rdata}, {96'h0, exp});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset state", ctrl_out, 128'h0);

    // R1 / R9: masked writes with several patterns on every register
    for (int k = 0; k < 8; k++) begin
      bus_write(8'(4*k), 16'h00FF, 16'hFFFF);
      check("R1 low-byte mask", ctrl_out, mdl_flat());
      bus_write(8'(4*k), 16'h0F0F, 16'h0000);
      check("R1 nibble mask", ctrl_out, mdl_flat());
      bus_write(8'(4*k), 16'hA5A5, 16'(16'h1357 * (k + 1)));
      check("R1 mixed mask", ctrl_out, mdl_flat());
      bus_write(8'(4*k), 16'h0000, 16'hFFFF);
      check("R1 empty mask", ctrl_out, mdl_flat());
      check("R9 slice", {112'h0, ctrl_out[k*16 +: 16]}, {112'h0, mdl[k]});
    end

    // R3: unmapped writes leave the bank unchanged
    bus_write(8'h20, 16'hFFFF, 16'hFFFF);
    check("R3 write past end", ctrl_out, mdl_flat());
    bus_write(8'h05, 16'hFFFF, 16'h0000);
    check("R3 misaligned write", ctrl_out, mdl_flat());
    bus_write(8'hFC, 16'hFFFF, 16'h1234);
    check("R3 top write", ctrl_out, mdl_flat());

    // R2 / R3: read sweep over every address
    @(negedge clk);
    for (int a = 0; a < 256; a++) read_check("R2 R3 read sweep", 8'(a));

    // R5 / R6 / R7: field sweep from two backgrounds
    for (int bg = 0; bg < 2; bg++) begin
      for (int k = 0; k < 8; k++)
        bus_write(8'(4*k), 16'hFFFF, bg == 0 ? 16'h5A5A : 16'hA5A5);
      for (int id = 0; id < 8; id++) begin
        for (int on = 0; on < 2; on++) begin
          field_write(id, on[0]);
          if (id >= 5) check("R7 unknown field id", ctrl_out, mdl_flat());
          else if (id <= 1) check("R6 single-bit field", ctrl_out, mdl_flat());
          else check("R5 field code", ctrl_out, mdl_flat());
        end
      end
    end

    // R6: toggle bit 13 and bit 14 of register 1 in turn
    bus_write(8'h04, 16'hFFFF, 16'h0000);
    field_write(0, 1'b1);
    check("R6 bit13 only", {112'h0, ctrl_out[31:16]}, {112'h0, 16'h2000});
    field_write(1, 1'b1);
    check("R6 bit14 keeps bit13", {112'h0, ctrl_out[31:16]}, {112'h0, 16'h6000});
    field_write(0, 1'b0);
    check("R6 clear bit13 keeps bit14", {112'h0, ctrl_out[31:16]}, {112'h0, 16'h4000});

    // R8: bus and field on the same register in one cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
    fld_req = 1'b1; fld_id = 3'd3; fld_on = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; fld_req = 1'b0;
    mdl[4] = 16'hFFFB;
    check("R8 same register merge", ctrl_out, mdl_flat());

    // R8: bus and field on different registers in one cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h00FF_0042;
    fld_req = 1'b1; fld_id = 3'd4; fld_on = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; fld_req = 1'b0;
    mdl[0] = (mdl[0] & 16'hFF00) | 16'h0042;
    mdl[7] = 16'h1100;
    check("R8 two registers", ctrl_out, mdl_flat());

    // R4: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    check("R4 reset mid-run", ctrl_out, 128'h0);
    read_check("R4 R2 read after reset", 8'h1C);

    finish_run();
  end
endmodule